// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by demanding a periodic service strobe inside a bounded time slot. Time is measured in ticks of a slow time-base input, nominally one per millisecond. Each supervision period is split in two equal halves. In the first half, the closed window, a service strobe counts as a fault. In the second half, the open window, a service strobe is accepted and a fresh period begins. A strobe in the closed window, or a period that runs out with no strobe, raises a system reset request for a fixed number of ticks and latches a sticky watchdog-reset flag.

A 2-bit select chooses the period length. Code 0 gives the longest period, `BASE_TICKS` ticks (80 by default). Each higher code halves the period, so the default lengths are 80, 40, 20 and 10 ticks. The select is sampled only when a period restarts. The flag is cleared by a write-one strobe from software or by power-on reset. All pins are plain control and status signals: there is no data stream and no back-pressure.

Top module: `wwdt_top`

## Requirements
- R1: With select code s latched, the period length is L = BASE_TICKS >> s ticks. With no service strobe, `rst_req` stays low for the first L-1 ticks after a restart and rises on the cycle after the L-th tick.
- R2: A service strobe while fewer than L/2 ticks have elapsed since the restart (closed window) is a fault. `rst_req` rises on the next cycle.
- R3: A service strobe after L/2 or more ticks (open window) raises no reset. It restarts the period at tick count zero, which begins a new closed window.
- R4: A timeout and a closed-window strobe produce the same fault: a reset request and the flag set.
- R5: `rst_req` goes high in the cycle after a fault and stays high for exactly RST_TICKS ticks. While it is high, service strobes are ignored. A new period starts when it drops.
- R6: `wd_flag` sets on every fault and holds until `flag_clr` is pulsed or `rst_n` is asserted. A fault in the same cycle as `flag_clr` leaves the flag set.
- R7: `per_sel` is sampled only at a restart: enable low, a valid strobe, or the cycle in which a reset pulse ends. A change in the middle of a period takes effect at the next period.
- R8: While `en` is low, the tick count is held at zero and no fault is raised. Raising `en` starts a full period.
- R9: A service strobe and a tick in the same cycle are judged on the tick count before that tick.
- R10: After `rst_n`, `rst_req` and `wd_flag` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| tick | input | 1 | One-cycle time-base pulse, one per period unit |
| en | input | 1 | Watchdog enable |
| per_sel | input | 2 | Period select: 0 is longest, each step halves the period |
| clr_stb | input | 1 | One-cycle software service strobe |
| flag_clr | input | 1 | One-cycle write-one strobe that clears the flag |
| rst_req | output | 1 | System reset request pulse |
| wd_flag | output | 1 | Sticky watchdog-reset flag |

## Verification
The bench builds the block with BASE_TICKS = 16 and RST_TICKS = 3, which gives periods of 16, 8, 4 and 2 ticks. With periods this short, every strobe position in every period setting can be swept, covering each tick on both sides of the window boundary and the timeout tick. At the same size, the corner orderings stay cheap to reach: a select change in mid-period, a strobe during the reset pulse, a strobe coinciding with a tick, and a fault coinciding with a flag clear.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int SEL_W = 2;
  localparam int N_SEL = 1 << SEL_W;

  // Period length in ticks for a given select code.
  function automatic int span(input int base, input int sel);
    return base >> sel;
  endfunction
endpackage

// File: rtl/wwdt_period.sv
module wwdt_period #(
  parameter int BASE_TICKS = 80,
  parameter int LW = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reload,
  input  logic [wwdt_pkg::SEL_W-1:0] sel,
  output logic [LW-1:0]              len,
  output logic [LW-1:0]              half
);
  logic [LW-1:0] lut [wwdt_pkg::N_SEL];
  logic [wwdt_pkg::SEL_W-1:0] sel_q;

  for (genvar i = 0; i < wwdt_pkg::N_SEL; i++) begin : g_lut
    assign lut[i] = LW'(wwdt_pkg::span(BASE_TICKS, i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (reload) sel_q <= sel;
  end

  assign len  = lut[sel_q];
  assign half = len >> 1;
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          hold,
  input  logic          clr_stb,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] half,
  output logic          fault,
  output logic          reload,
  output logic [LW-1:0] cnt
);
  logic [LW-1:0] cnt_q;
  logic live, closed, last, good;

  assign live   = en && !hold;
  assign closed = cnt_q < half;
  assign last   = cnt_q == (len - LW'(1));
  assign fault  = live && ((clr_stb && closed) || (!clr_stb && tick && last));
  assign good   = live && clr_stb && !closed;
  assign reload = !live || fault || good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (reload) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + LW'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wwdt_pulse.sv
module wwdt_pulse #(
  parameter int RST_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fault,
  input  logic flag_clr,
  output logic active,
  output logic flag
);
  localparam int PW = $clog2(RST_TICKS + 1);
  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pcnt   <= '0;
    end else if (fault) begin
      active <= 1'b1;
      pcnt   <= '0;
    end else if (active && tick) begin
      if (pcnt == PW'(RST_TICKS - 1)) active <= 1'b0;
      pcnt <= pcnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (fault)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top #(
  parameter int BASE_TICKS = 80,
  parameter int RST_TICKS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       en,
  input  logic [wwdt_pkg::SEL_W-1:0] per_sel,
  input  logic                       clr_stb,
  input  logic                       flag_clr,
  output logic                       rst_req,
  output logic                       wd_flag
);
  localparam int LW = $clog2(BASE_TICKS + 1);

  logic [LW-1:0] len_w, half_w, cnt_w;
  logic fault_w, reload_w, active_w;

  wwdt_period #(.BASE_TICKS(BASE_TICKS), .LW(LW)) u_period (
    .clk(clk), .rst_n(rst_n), .reload(reload_w), .sel(per_sel),
    .len(len_w), .half(half_w)
  );

  wwdt_window #(.LW(LW)) u_window (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .hold(active_w),
    .clr_stb(clr_stb), .len(len_w), .half(half_w),
    .fault(fault_w), .reload(reload_w), .cnt(cnt_w)
  );

  wwdt_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault(fault_w),
    .flag_clr(flag_clr), .active(active_w), .flag(wd_flag)
  );

  assign rst_req = active_w;
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          en,
  input logic          clr_stb,
  input logic          flag_clr,
  input logic          rst_req,
  input logic          wd_flag,
  input logic [LW-1:0] cnt,
  input logic [LW-1:0] len,
  input logic [LW-1:0] half
);
  assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

  assert_open_clear_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rst_req && clr_stb && cnt >= half) |=> (cnt == '0 && !rst_req));

  assert_pulse_ends_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !tick) |=> rst_req);

  assert_flag_with_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> wd_flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !flag_clr) |=> wd_flag);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rst_req) |=> !rst_req);
endmodule

bind wwdt_top wwdt_checker #(.LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .clr_stb(clr_stb),
  .flag_clr(flag_clr), .rst_req(rst_req), .wd_flag(wd_flag),
  .cnt(cnt_w), .len(len_w), .half(half_w)
);

// File: tb/test_wwdt_top.sv
module test_wwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;
  localparam int RSTT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, clr_stb = 1'b0, flag_clr = 1'b0;
  logic [1:0] per_sel = 2'd0;
  logic rst_req, wd_flag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_top #(.BASE_TICKS(BASE), .RST_TICKS(RSTT)) i_wwdt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .per_sel(per_sel),
    .clr_stb(clr_stb), .flag_clr(flag_clr), .rst_req(rst_req), .wd_flag(wd_flag)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic c, input logic fc);
    tick = t; clr_stb = c; flag_clr = fc;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; clr_stb = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic restart(input int s);
    en = 1'b0; per_sel = 2'(s);
    repeat (RSTT) step(1'b1, 1'b0, 1'b1);
    en = 1'b1;
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rst_req", rst_req, 1'b0);
    check("R10 wd_flag", wd_flag, 1'b0);

    // R2/R3: sweep strobe position for every select code
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < (BASE >> s); k++) begin
        restart(s);
        repeat (k) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check((k < (BASE >> s) / 2) ? "R2 closed strobe" : "R3 open strobe",
              rst_req, 1'(k < (BASE >> s) / 2));
        check("R4 flag", wd_flag, 1'(k < (BASE >> s) / 2));
      end
      // R1/R4: timeout
      restart(s);
      repeat ((BASE >> s) - 1) step(1'b1, 1'b0, 1'b0);
      check("R1 before timeout", rst_req, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      check("R1 timeout", rst_req, 1'b1);
      check("R4 timeout flag", wd_flag, 1'b1);
    end

    // R3: full new period after a valid strobe
    restart(0);
    repeat (BASE / 2) step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R3 accepted", rst_req, 1'b0);
    repeat (BASE - 1) step(1'b1, 1'b0, 1'b0);
    check("R3 new period", rst_req, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R3 new period end", rst_req, 1'b1);

    // R5: pulse length, strobe ignored during it
    step(1'b0, 1'b1, 1'b0);
    check("R5 strobe in pulse", rst_req, 1'b1);
    repeat (RSTT - 1) step(1'b1, 1'b0, 1'b0);
    check("R5 pulse held", rst_req, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    check("R5 pulse end", rst_req, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R5 fresh closed window", rst_req, 1'b1);

    // R6: sticky flag, clear, set wins
    repeat (RSTT) step(1'b1, 1'b0, 1'b0);
    check("R6 flag after pulse", wd_flag, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check("R6 flag cleared", wd_flag, 1'b0);
    restart(0);
    step(1'b0, 1'b1, 1'b1);
    check("R6 set wins", wd_flag, 1'b1);

    // R7: mid-period select change ignored until restart
    restart(0);
    per_sel = 2'd3;
    repeat (BASE - 1) step(1'b1, 1'b0, 1'b0);
    check("R7 old period kept", rst_req, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R7 old period end", rst_req, 1'b1);
    repeat (RSTT) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R7 new short period", rst_req, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R7 new short timeout", rst_req, 1'b1);

    // R8: disable holds
    restart(0);
    en = 1'b0;
    repeat (3 * BASE) step(1'b1, 1'b0, 1'b0);
    check("R8 off no fault", rst_req, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check("R8 off strobe", rst_req, 1'b0);
    en = 1'b1;
    repeat (BASE - 1) step(1'b1, 1'b0, 1'b0);
    check("R8 full period on enable", rst_req, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    check("R8 timeout after enable", rst_req, 1'b1);

    // R9: strobe and tick together
    restart(0);
    repeat (BASE / 2 - 1) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R9 judged before tick", rst_req, 1'b1);
    restart(0);
    repeat (BASE - 1) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R9 last tick strobe wins", rst_req, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule